// File: doc/BRIEF.md
# Load/Store Address Generation Sequencer

This block executes the data-movement group of a 16-bit teaching processor: PC-relative load and store, base-plus-offset load and store, indirect (pointer-then-data) load and store, and the address-only form that writes a computed address into a register. An instruction is presented together with the already-incremented program counter. In the issue cycle the block reads the base and source registers through two combinational register-file read ports. One shared adder forms the effective address. The block then runs the memory accesses that the form needs through a request/ready memory port.

When the sequence finishes, the block raises a one-cycle completion pulse. A load or an address-only instruction also writes the result register and updates the negative/zero/positive flags in that same cycle. A busy output covers the whole sequence, and the block accepts no new instruction while it is high. Opcodes outside the group are not accepted, so the surrounding pipeline can present every instruction to the block.

Top module: `ldst_agen_seq`

## Requirements
- R1: Only the opcodes in issue_instr[15:12] are accepted: 0010 PC-relative load, 0011 PC-relative store, 0110 base load, 0111 base store, 1010 indirect load, 1011 indirect store, 1110 address-only. Any other opcode is ignored: busy stays 0, no memory request is made and no done pulse follows.
- R2: PC-relative load: the address is issue_pc plus sign-extended issue_instr[8:0]. The block makes exactly one memory read there and writes the data to the register named by issue_instr[11:9].
- R3: PC-relative store: the block makes exactly one memory write, at the same address as R2, of the register named by issue_instr[11:9]. No register is written.
- R4: Base load/store: the address is the register named by issue_instr[8:6] plus sign-extended issue_instr[5:0]. The block makes one access, with the same data roles as R2/R3.
- R5: Indirect load/store: the first access reads a pointer at issue_pc plus sign-extended issue_instr[8:0]. The second access reads or writes the data at that pointer. That is exactly two accesses.
- R6: Address-only: the register named by issue_instr[11:9] receives issue_pc plus sign-extended issue_instr[8:0]. No memory access is made, and done rises in the first cycle after the issue edge.
- R7: Once mem_req rises, mem_req, mem_addr, mem_we and mem_wdata stay unchanged until a cycle in which mem_ready is high, which completes that access.
- R8: done is high for exactly one cycle per accepted instruction. rf_we and flag_we are high only in that cycle, and only for loads and address-only instructions. rf_wdata then holds the result.
- R9: With flag_we high, flag_nzp is one-hot: bit 2 for a negative result (bit 15 set), bit 1 for zero, bit 0 for positive.
- R10: busy is high from the cycle after an accepted issue through the done cycle, and falls in the cycle after done. issue_valid is ignored while busy is high.
- R11: After reset, busy, mem_req, done, rf_we and flag_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| issue_instr | input | 16 | Instruction word |
| issue_pc | input | 16 | Incremented program counter |
| busy | output | 1 | Sequence in progress |
| rf_base_sel | output | 3 | Base register read address (issue_instr[8:6]) |
| rf_base_data | input | 16 | Base register read data |
| rf_src_sel | output | 3 | Source register read address (issue_instr[11:9]) |
| rf_src_data | input | 16 | Source register read data |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 3 | Register write address |
| rf_wdata | output | 16 | Register write data |
| flag_we | output | 1 | Condition flag update strobe |
| flag_nzp | output | 3 | Negative/zero/positive flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | Instruction completion pulse |

## Verification
On every cycle the assertions check that a request holds while the memory stalls and that done is a single-cycle pulse. They also check that register and flag strobes appear only with done, that the flags are one-hot, and that busy falls after done. Only the bench scenarios can show that each addressing form reaches the correct address and moves the correct data. They also show that indirect forms make two accesses and the address-only form none, and that foreign opcodes and issues during busy leave no trace.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int ILEN   = 16;
    localparam int OPC_W  = 4;
    localparam int RSEL_W = 3;
    localparam int OFFL_W = 9;
    localparam int OFFS_W = 6;

    localparam logic [OPC_W-1:0] OPC_LD_PC  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ST_PC  = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_LD_BAS = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_ST_BAS = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_LD_IND = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_ST_IND = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_ADDR   = 4'b1110;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACC  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              legal;
        logic              is_store;
        logic              addr_only;
        logic              indirect;
        logic              base_mode;
        logic [RSEL_W-1:0] reg_sel;
        logic [RSEL_W-1:0] base_sel;
        logic [OFFL_W-1:0] off_long;
        logic [OFFS_W-1:0] off_short;
    } ldst_dec_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output ldst_dec_t       dec
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc           = instr[ILEN-1 -: OPC_W];
        dec           = '0;
        dec.reg_sel   = instr[11:9];
        dec.base_sel  = instr[8:6];
        dec.off_long  = instr[OFFL_W-1:0];
        dec.off_short = instr[OFFS_W-1:0];
        unique case (opc)
            OPC_LD_PC:  dec.legal = 1'b1;
            OPC_ST_PC:  begin dec.legal = 1'b1; dec.is_store = 1'b1; end
            OPC_LD_BAS: begin dec.legal = 1'b1; dec.base_mode = 1'b1; end
            OPC_ST_BAS: begin dec.legal = 1'b1; dec.base_mode = 1'b1; dec.is_store = 1'b1; end
            OPC_LD_IND: begin dec.legal = 1'b1; dec.indirect = 1'b1; end
            OPC_ST_IND: begin dec.legal = 1'b1; dec.indirect = 1'b1; dec.is_store = 1'b1; end
            OPC_ADDR:   begin dec.legal = 1'b1; dec.addr_only = 1'b1; end
            default:    dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
    import ldst_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              base_mode,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFFL_W-1:0] off_long,
    input  logic [OFFS_W-1:0] off_short,
    output logic [DATA_W-1:0] eff_addr
);
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;

    always_comb begin
        if (base_mode) begin
            opnd_a = base_val;
            opnd_b = {{(DATA_W-OFFS_W){off_short[OFFS_W-1]}}, off_short};
        end else begin
            opnd_a = pc;
            opnd_b = {{(DATA_W-OFFL_W){off_long[OFFL_W-1]}}, off_long};
        end
        eff_addr = opnd_a + opnd_b;
    end
endmodule

// File: rtl/ldst_flags.sv
module ldst_flags #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    output logic [2:0]        nzp
);
    always_comb begin
        if (value[DATA_W-1])      nzp = 3'b100;
        else if (value == '0)     nzp = 3'b010;
        else                      nzp = 3'b001;
    end
endmodule

// File: rtl/ldst_agen_seq.sv
module ldst_agen_seq
    import ldst_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [ILEN-1:0]     issue_instr,
    input  logic [DATA_W-1:0]   issue_pc,
    output logic                busy,
    output logic [RSEL_W-1:0]   rf_base_sel,
    input  logic [DATA_W-1:0]   rf_base_data,
    output logic [RSEL_W-1:0]   rf_src_sel,
    input  logic [DATA_W-1:0]   rf_src_data,
    output logic                rf_we,
    output logic [RSEL_W-1:0]   rf_waddr,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic                flag_we,
    output logic [2:0]          flag_nzp,
    output logic                mem_req,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ready,
    output logic                done
);
    typedef struct packed {
        seq_state_e        st;
        logic              ptr_phase;
        logic              is_store;
        logic              wr_reg;
        logic [RSEL_W-1:0] dst;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] result;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    ldst_dec_t         dec;
    logic [DATA_W-1:0] eff_addr;

    ldst_decode u_dec (
        .instr (issue_instr),
        .dec   (dec)
    );

    ldst_agen #(.DATA_W(DATA_W)) u_agen (
        .base_mode (dec.base_mode),
        .pc        (issue_pc),
        .base_val  (rf_base_data),
        .off_long  (dec.off_long),
        .off_short (dec.off_short),
        .eff_addr  (eff_addr)
    );

    ldst_flags #(.DATA_W(DATA_W)) u_flags (
        .value (r_q.result),
        .nzp   (flag_nzp)
    );

    assign rf_base_sel = dec.base_sel;
    assign rf_src_sel  = dec.reg_sel;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (issue_valid && dec.legal) begin
                    r_d.dst       = dec.reg_sel;
                    r_d.addr      = eff_addr;
                    r_d.wdata     = rf_src_data;
                    r_d.is_store  = dec.is_store;
                    r_d.ptr_phase = dec.indirect;
                    r_d.wr_reg    = !dec.is_store;
                    if (dec.addr_only) begin
                        r_d.result = eff_addr;
                        r_d.st     = SEQ_FIN;
                    end else begin
                        r_d.st     = SEQ_ACC;
                    end
                end
            end
            SEQ_ACC: begin
                if (mem_ready) begin
                    if (r_q.ptr_phase) begin
                        r_d.addr      = mem_rdata;
                        r_d.ptr_phase = 1'b0;
                    end else begin
                        if (!r_q.is_store) r_d.result = mem_rdata;
                        r_d.st = SEQ_FIN;
                    end
                end
            end
            SEQ_FIN: begin
                r_d.st = SEQ_IDLE;
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != SEQ_IDLE);
    assign mem_req   = (r_q.st == SEQ_ACC);
    assign mem_we    = r_q.is_store && !r_q.ptr_phase;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign done      = (r_q.st == SEQ_FIN);
    assign rf_we     = done && r_q.wr_reg;
    assign flag_we   = done && r_q.wr_reg;
    assign rf_waddr  = r_q.dst;
    assign rf_wdata  = r_q.result;

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rf_we,
    input logic              flag_we,
    input logic [2:0]        flag_nzp,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              done
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_RF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done); // R8
    AST_FLAG_WITH_RF: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> rf_we); // R8
    AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> $countones(flag_nzp) == 1); // R9
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !done); // R1
endmodule

bind ldst_agen_seq ldst_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rf_we     (rf_we),
    .flag_we   (flag_we),
    .flag_nzp  (flag_nzp),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done)
);

// File: tb/tb_ldst_agen_seq.sv
`timescale 1ns/1ps
module tb_ldst_agen_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [15:0] issue_instr = '0;
    logic [15:0] issue_pc = '0;
    logic        busy;
    logic [2:0]  rf_base_sel, rf_src_sel, rf_waddr;
    logic [15:0] rf_base_data, rf_src_data, rf_wdata;
    logic        rf_we, flag_we, mem_req, mem_we, done;
    logic [2:0]  flag_nzp;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2.5 clk = ~clk;

    ldst_agen_seq dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .issue_pc(issue_pc), .busy(busy), .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
        .rf_src_sel(rf_src_sel), .rf_src_data(rf_src_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .flag_we(flag_we), .flag_nzp(flag_nzp), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .done(done)
    );

    int tests = 0;
    int fails = 0;

    logic [15:0] rf  [8];
    logic [15:0] mem [256];
    assign rf_base_data = rf[rf_base_sel];
    assign rf_src_data  = rf[rf_src_sel];

    typedef struct {
        string       tag;
        bit          wr;
        logic [2:0]  rdst;
        logic [15:0] val;
        logic [2:0]  nzp;
        logic [7:0]  st_idx;
        int          acc;
    } exp_t;
    exp_t sb[$];

    int lat = 0;
    int wait_cnt = 0;
    int acc_cnt = 0;
    int done_cnt = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Memory model: answers after lat waiting cycles, evaluated away from the active edge
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ready = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                wait_cnt = 0;
            end else begin
                mem_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wait_cnt = 0;
        end
    end

    always @(posedge clk) if (mem_req && mem_ready) acc_cnt++;

    // R7: a stalled request must look the same one cycle later
    logic        prev_stall = 1'b0;
    logic [15:0] prev_addr;
    logic        prev_we;
    logic [15:0] prev_wd;
    always @(negedge clk) begin
        #0.1;
        if (prev_stall)
            check(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
                  "R7", "request held", mem_addr, prev_addr);
        prev_stall = mem_req && !mem_ready;
        prev_addr  = mem_addr;
        prev_we    = mem_we;
        prev_wd    = mem_wdata;
    end

    // Monitor: pops the scoreboard on each completion
    always @(negedge clk) begin
        if (done) begin
            done_cnt++;
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected completion", {15'd0, done}, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rf_we == e.wr, e.tag, "rf_we", {15'd0, rf_we}, {15'd0, e.wr});
                check(flag_we == e.wr, e.tag, "flag_we (R8)", {15'd0, flag_we}, {15'd0, e.wr});
                check(acc_cnt == e.acc, e.tag, "access count", acc_cnt[15:0], e.acc[15:0]);
                if (e.wr) begin
                    check(rf_waddr == e.rdst, e.tag, "dest reg", {13'd0, rf_waddr}, {13'd0, e.rdst});
                    check(rf_wdata == e.val, e.tag, "result", rf_wdata, e.val);
                    check(flag_nzp == e.nzp, "R9", "flags", {13'd0, flag_nzp}, {13'd0, e.nzp});
                end else begin
                    check(mem[e.st_idx] == e.val, e.tag, "stored word", mem[e.st_idx], e.val);
                end
            end
        end
    end

    function automatic logic [15:0] sx9(input logic [15:0] i);
        return {{7{i[8]}}, i[8:0]};
    endfunction
    function automatic logic [15:0] sx6(input logic [15:0] i);
        return {{10{i[5]}}, i[5:0]};
    endfunction
    function automatic logic [2:0] nzp_of(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'd0) return 3'b010;
        return 3'b001;
    endfunction

    // Driver: computes the expected item, pushes it, issues, waits for completion
    task automatic issue(input string tag, input logic [15:0] ins, input logic [15:0] pc, input int l);
        exp_t e;
        logic [15:0] a, p;
        logic [3:0] op;
        while (busy) @(negedge clk);
        op = ins[15:12];
        e.tag = tag; e.rdst = ins[11:9]; e.st_idx = '0; e.wr = 1'b1; e.acc = 1;
        a = (op == 4'b0110 || op == 4'b0111) ? rf[ins[8:6]] + sx6(ins) : pc + sx9(ins);
        p = mem[a[7:0]];
        case (op)
            4'b0010, 4'b0110: e.val = mem[a[7:0]];
            4'b1010: begin e.val = mem[p[7:0]]; e.acc = 2; end
            4'b1110: begin e.val = a; e.acc = 0; end
            4'b0011, 4'b0111: begin e.wr = 1'b0; e.val = rf[ins[11:9]]; e.st_idx = a[7:0]; end
            default: begin e.wr = 1'b0; e.val = rf[ins[11:9]]; e.st_idx = p[7:0]; e.acc = 2; end
        endcase
        e.nzp = nzp_of(e.val);
        lat = l;
        acc_cnt = 0;
        sb.push_back(e);
        issue_valid = 1'b1; issue_instr = ins; issue_pc = pc;
        @(negedge clk);
        issue_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d0;
        for (int i = 0; i < 8; i++) rf[i] = 16'h1111 * i[15:0];
        rf[1] = 16'h0080;
        rf[2] = 16'hBEEF;
        rf[6] = 16'h0123;
        for (int i = 0; i < 256; i++) mem[i] = (i[15:0] * 16'h0131) ^ 16'h2A00;
        mem[8'h30] = 16'h0000;
        mem[8'h45] = 16'h7ABC;
        mem[8'h7D] = 16'h9000;
        mem[8'h60] = 16'h00A5;
        mem[8'hA5] = 16'h8001;
        mem[8'h61] = 16'h00B0;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !done && !rf_we && !flag_we, "R11", "reset outputs",
              {11'd0, busy, mem_req, done, rf_we, flag_we}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue("R2",  {4'b0010, 3'd3, 9'h005}, 16'h0040, 0);          // pc-rel load, positive
        issue("R2",  {4'b0010, 3'd4, 9'h1F0}, 16'h0040, 2);          // negative offset, zero data
        issue("R3",  {4'b0011, 3'd2, 9'h012}, 16'h0050, 1);          // pc-rel store
        issue("R4",  {4'b0110, 3'd5, 3'd1, 6'h3D}, 16'h0000, 3);     // base load, offset -3
        issue("R4",  {4'b0111, 3'd6, 3'd1, 6'h1F}, 16'h0000, 0);     // base store, offset +31
        issue("R5",  {4'b1010, 3'd7, 9'h020}, 16'h0040, 1);          // indirect load
        issue("R5",  {4'b1011, 3'd2, 9'h021}, 16'h0040, 0);          // indirect store
        issue("R6",  {4'b1110, 3'd1, 9'h1FF}, 16'h3000, 0);          // address-only, -1
        issue("R6",  {4'b1110, 3'd0, 9'h005}, 16'h8000, 0);          // address-only, negative

        // R1: foreign opcode presented for one cycle leaves the block idle
        d0 = done_cnt;
        issue_valid = 1'b1; issue_instr = 16'h1234; issue_pc = 16'h0040;
        @(negedge clk);
        issue_valid = 1'b0;
        check(!busy && !mem_req, "R1", "foreign opcode idle", {14'd0, busy, mem_req}, 16'd0);
        repeat (3) @(negedge clk);
        check(done_cnt == d0 && !busy, "R1", "no completion", done_cnt[15:0], d0[15:0]);

        // R10: issue held high during a busy load is not accepted
        d0 = done_cnt;
        begin
            exp_t e;
            e.tag = "R10"; e.wr = 1'b1; e.rdst = 3'd3; e.val = mem[8'h45];
            e.nzp = nzp_of(e.val); e.st_idx = '0; e.acc = 1;
            lat = 4; acc_cnt = 0;
            sb.push_back(e);
        end
        issue_valid = 1'b1; issue_instr = {4'b0010, 3'd3, 9'h005}; issue_pc = 16'h0040;
        @(negedge clk);
        issue_instr = {4'b1110, 3'd5, 9'h011};
        check(busy, "R10", "busy after issue", {15'd0, busy}, 16'd1);
        while (busy) @(negedge clk);
        issue_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(done_cnt == d0 + 1, "R10", "single completion", done_cnt[15:0], d0[15:0] + 16'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule